// File: doc/BRIEF.md
# UART Modem Loopback Controller

This block provides the self-test path of a UART. It holds the control register with the loopback enable and four software-driven modem outputs. It produces the nine-bit modem status flag word and the four modem-status interrupt bits. It also decides what enters the receive buffer in each cycle.

With loopback off, the status flags follow the external modem pins through a synchronizer. External receive characters and break events are pushed into the receive buffer. With loopback on, the flags are a fixed cross-mapping of the control outputs, applied on the same edge as the register write. Every transmitted byte and every rising edge of the break control are fed back into the receive buffer, and all external receive traffic is dropped. Transmitted bytes always go out to the serial line as well.

The receive buffer takes one 11-bit word per cycle. Bits 7:0 carry data, and bit 10 marks a break character. Baud generation and framing belong to other blocks.

Top module: `uart_lpbk_ctrl`

## Requirements
- R1: After synchronous reset, `ctrl_q` reads 0x0300, `status_flags` and `ms_irq` read zero, `line_break` is low and no word is pushed.
- R2: A write with `ctrl_we` stores all 16 bits of `ctrl_wdata` into `ctrl_q` on that clock edge.
- R3: When the written control value has bit 7 (loopback enable) set, `status_flags` take the mapping on the same edge, including on the write that first sets bit 7. The mapping is: flag bit 8 = control bit 13, flag bit 2 = control bit 12, flag bit 0 = control bit 11, flag bit 1 = control bit 10. Flag bits 7:3 are zero.
- R4: With loopback off, flag bits 8, 2, 0 and 1 follow the modem inputs ri, dcd, cts and dsr, three edges after the input changes (two synchronizer stages plus the flag register).
- R5: Every control write with bit 7 set loads `ms_irq` with the mapped flag values: bit 0 = ri, bit 1 = cts, bit 2 = dcd, bit 3 = dsr. This clears bits whose flag is zero. Otherwise each `irq_clr` bit clears the matching `ms_irq` bit. When a write and a clear coincide, the write wins.
- R6: A `tx_valid` byte appears on `ser_tx_valid`/`ser_tx_byte` one edge later in every mode. In loopback, the same byte is also pushed as word {3'b000, byte} on that edge.
- R7: In loopback, a `brk_we` write that takes `line_break` from 0 to 1 pushes 0x400. A write that leaves the level high or lowers it pushes nothing. `line_break` shows the written level from the next edge.
- R8: When a loopback break push meets a loopback transmit push in the same cycle, the transmit byte goes first. The break word is pushed in the first later cycle without a transmit push.
- R9: In loopback, `ext_rx_valid` words (data or break) produce no push, and the modem inputs do not change `status_flags`.
- R10: With loopback off, `ext_rx_valid` pushes one edge later either {3'b000, `ext_rx_byte`} or, when `ext_rx_brk` is set, 0x400. A break control rise pushes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 16 | Control register write value |
| ctrl_q | output | 16 | Control register contents |
| irq_clr | input | 4 | Per-bit clear of the modem interrupt bits |
| modem_ri_in | input | 1 | External ring indicator (asynchronous) |
| modem_dcd_in | input | 1 | External carrier detect (asynchronous) |
| modem_cts_in | input | 1 | External clear to send (asynchronous) |
| modem_dsr_in | input | 1 | External data set ready (asynchronous) |
| status_flags | output | 9 | Modem status flag word |
| ms_irq | output | 4 | Modem status interrupt bits |
| tx_valid | input | 1 | Transmit byte write strobe |
| tx_byte | input | 8 | Transmit byte |
| ser_tx_valid | output | 1 | Byte forwarded to the serial transmitter |
| ser_tx_byte | output | 8 | Forwarded transmit byte |
| brk_we | input | 1 | Break control write strobe |
| brk_val | input | 1 | Break control write value |
| line_break | output | 1 | Current break control level |
| ext_rx_valid | input | 1 | External receive word valid |
| ext_rx_byte | input | 8 | External receive data |
| ext_rx_brk | input | 1 | External receive word is a break |
| rx_push_valid | output | 1 | Push into receive buffer |
| rx_push_word | output | 11 | Pushed word, bit 10 = break |

## Verification
A wrong control or mapping state shows on `status_flags` at the first sample after the write. The same holds for the enabling write itself. A bad synchronizer depth shows as a flag change one edge early or late. A corrupted interrupt register shows on `ms_irq` on the cycle after a write or a clear. A lost pending break or a wrong mux choice shows as a missing, extra or reordered word on `rx_push_word`, one or two cycles after the stimulus.

// File: rtl/uart_lb_pkg.sv
package uart_lb_pkg;

    localparam int DATA_W   = 8;
    localparam int CTRL_W   = 16;
    localparam int FLAG_W   = 9;
    localparam int MS_W     = 4;
    localparam int BRK_POS  = 10;
    localparam int RXW      = BRK_POS + 1;

    // control register fields
    localparam int C_OUT2   = 13;
    localparam int C_OUT1   = 12;
    localparam int C_RTS    = 11;
    localparam int C_DTR    = 10;
    localparam int C_LBE    = 7;
    localparam logic [CTRL_W-1:0] CTRL_RST = 16'h0300;

    // status flag positions
    localparam int F_RI     = 8;
    localparam int F_DCD    = 2;
    localparam int F_DSR    = 1;
    localparam int F_CTS    = 0;

    // interrupt bit positions
    localparam int I_RI     = 0;
    localparam int I_CTS    = 1;
    localparam int I_DCD    = 2;
    localparam int I_DSR    = 3;

    localparam logic [RXW-1:0] BRK_WORD = RXW'(1) << BRK_POS;

    typedef struct packed {
        logic ri;
        logic dcd;
        logic cts;
        logic dsr;
    } modem_t;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_TX,
        SRC_BRK,
        SRC_EXT
    } push_src_e;

    function automatic modem_t ctrl_to_modem(input logic [CTRL_W-1:0] c);
        modem_t m;
        m.ri  = c[C_OUT2];
        m.dcd = c[C_OUT1];
        m.cts = c[C_RTS];
        m.dsr = c[C_DTR];
        return m;
    endfunction

    function automatic logic [FLAG_W-1:0] modem_to_flags(input modem_t m);
        logic [FLAG_W-1:0] f;
        f        = '0;
        f[F_RI]  = m.ri;
        f[F_DCD] = m.dcd;
        f[F_DSR] = m.dsr;
        f[F_CTS] = m.cts;
        return f;
    endfunction

    function automatic logic [MS_W-1:0] modem_to_irq(input modem_t m);
        logic [MS_W-1:0] v;
        v        = '0;
        v[I_RI]  = m.ri;
        v[I_CTS] = m.cts;
        v[I_DCD] = m.dcd;
        v[I_DSR] = m.dsr;
        return v;
    endfunction

endpackage

// File: rtl/lb_modem_sync.sv
module lb_modem_sync #(
    parameter int N      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);
    for (genvar b = 0; b < N; b++) begin : g_bit
        logic [STAGES-1:0] sh;
        always_ff @(posedge clk) begin
            if (rst) sh <= '0;
            else     sh <= {sh[STAGES-2:0], d_i[b]};
        end
        assign q_o[b] = sh[STAGES-1];
    end
endmodule

// File: rtl/lb_ctrl_regs.sv
module lb_ctrl_regs
    import uart_lb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic [MS_W-1:0]   irq_clr,
    input  modem_t            ext_modem,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [FLAG_W-1:0] flags_q,
    output logic [MS_W-1:0]   irq_q,
    output logic              lb_en
);
    logic [CTRL_W-1:0] ctrl_nx;
    logic              lb_nx;
    modem_t            mapped;
    logic [FLAG_W-1:0] flags_nx;
    logic [MS_W-1:0]   irq_nx;

    always_comb begin
        ctrl_nx  = ctrl_we ? ctrl_wdata : ctrl_q;
        lb_nx    = ctrl_nx[C_LBE];
        mapped   = ctrl_to_modem(ctrl_nx);
        flags_nx = lb_nx ? modem_to_flags(mapped) : modem_to_flags(ext_modem);
        if (ctrl_we && ctrl_wdata[C_LBE]) irq_nx = modem_to_irq(mapped);
        else                              irq_nx = irq_q & ~irq_clr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= CTRL_RST;
            flags_q <= '0;
            irq_q   <= '0;
        end else begin
            ctrl_q  <= ctrl_nx;
            flags_q <= flags_nx;
            irq_q   <= irq_nx;
        end
    end

    assign lb_en = ctrl_q[C_LBE];
endmodule

// File: rtl/lb_rx_mux.sv
module lb_rx_mux
    import uart_lb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lb_en,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              brk_we,
    input  logic              brk_val,
    input  logic              ext_rx_valid,
    input  logic [DATA_W-1:0] ext_rx_byte,
    input  logic              ext_rx_brk,
    output logic              push_valid,
    output logic [RXW-1:0]    push_word,
    output logic              brk_q,
    output logic              ser_tx_valid,
    output logic [DATA_W-1:0] ser_tx_byte
);
    logic      pend_q;
    logic      brk_rise;
    logic      want_brk;
    push_src_e src;
    logic [RXW-1:0] word_nx;

    always_comb begin
        brk_rise = brk_we && brk_val && !brk_q;
        want_brk = lb_en && (pend_q || brk_rise);
        if (lb_en && tx_valid)          src = SRC_TX;
        else if (want_brk)              src = SRC_BRK;
        else if (!lb_en && ext_rx_valid) src = SRC_EXT;
        else                            src = SRC_NONE;
        case (src)
            SRC_TX:  word_nx = {{(RXW-DATA_W){1'b0}}, tx_byte};
            SRC_BRK: word_nx = BRK_WORD;
            SRC_EXT: word_nx = ext_rx_brk ? BRK_WORD
                                          : {{(RXW-DATA_W){1'b0}}, ext_rx_byte};
            default: word_nx = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q       <= 1'b0;
            brk_q        <= 1'b0;
            push_valid   <= 1'b0;
            push_word    <= '0;
            ser_tx_valid <= 1'b0;
            ser_tx_byte  <= '0;
        end else begin
            pend_q       <= want_brk && (src != SRC_BRK);
            if (brk_we) brk_q <= brk_val;
            push_valid   <= (src != SRC_NONE);
            push_word    <= word_nx;
            ser_tx_valid <= tx_valid;
            if (tx_valid) ser_tx_byte <= tx_byte;
        end
    end
endmodule

// File: rtl/uart_lpbk_ctrl.sv
module uart_lpbk_ctrl
    import uart_lb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    input  logic [MS_W-1:0]   irq_clr,
    input  logic              modem_ri_in,
    input  logic              modem_dcd_in,
    input  logic              modem_cts_in,
    input  logic              modem_dsr_in,
    output logic [FLAG_W-1:0] status_flags,
    output logic [MS_W-1:0]   ms_irq,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              ser_tx_valid,
    output logic [DATA_W-1:0] ser_tx_byte,
    input  logic              brk_we,
    input  logic              brk_val,
    output logic              line_break,
    input  logic              ext_rx_valid,
    input  logic [DATA_W-1:0] ext_rx_byte,
    input  logic              ext_rx_brk,
    output logic              rx_push_valid,
    output logic [RXW-1:0]    rx_push_word
);
    logic [MS_W-1:0] raw_modem;
    logic [MS_W-1:0] sync_modem;
    logic            lb_en;

    assign raw_modem = {modem_ri_in, modem_dcd_in, modem_cts_in, modem_dsr_in};

    lb_modem_sync #(.N(MS_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_modem),
        .q_o (sync_modem)
    );

    lb_ctrl_regs i_regs (
        .clk        (clk),
        .rst        (rst),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .irq_clr    (irq_clr),
        .ext_modem  (modem_t'(sync_modem)),
        .ctrl_q     (ctrl_q),
        .flags_q    (status_flags),
        .irq_q      (ms_irq),
        .lb_en      (lb_en)
    );

    lb_rx_mux i_mux (
        .clk          (clk),
        .rst          (rst),
        .lb_en        (lb_en),
        .tx_valid     (tx_valid),
        .tx_byte      (tx_byte),
        .brk_we       (brk_we),
        .brk_val      (brk_val),
        .ext_rx_valid (ext_rx_valid),
        .ext_rx_byte  (ext_rx_byte),
        .ext_rx_brk   (ext_rx_brk),
        .push_valid   (rx_push_valid),
        .push_word    (rx_push_word),
        .brk_q        (line_break),
        .ser_tx_valid (ser_tx_valid),
        .ser_tx_byte  (ser_tx_byte)
    );
endmodule

// File: rtl/uart_lpbk_ctrl_chk.sv
module uart_lpbk_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        ctrl_we,
    input logic [15:0] ctrl_wdata,
    input logic [15:0] ctrl_q,
    input logic [8:0]  status_flags,
    input logic [3:0]  ms_irq,
    input logic        tx_valid,
    input logic [7:0]  tx_byte,
    input logic        ser_tx_valid,
    input logic [7:0]  ser_tx_byte,
    input logic        ext_rx_valid,
    input logic        rx_push_valid,
    input logic [10:0] rx_push_word
);
    p_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctrl_q == 16'h0300 && ms_irq == 4'h0 && !rx_push_valid));

    p_map_r3: assert property (@(posedge clk) disable iff (rst)
        ctrl_q[7] |-> status_flags == {ctrl_q[13], 5'b0, ctrl_q[12], ctrl_q[10], ctrl_q[11]});

    p_irq_load_r5: assert property (@(posedge clk) disable iff (rst)
        (ctrl_we && ctrl_wdata[7]) |=>
        ms_irq == {$past(ctrl_wdata[10]), $past(ctrl_wdata[12]),
                   $past(ctrl_wdata[11]), $past(ctrl_wdata[13])});

    p_tx_line_r6: assert property (@(posedge clk) disable iff (rst)
        tx_valid |=> (ser_tx_valid && ser_tx_byte == $past(tx_byte)));

    p_tx_loop_r6: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q[7] && tx_valid) |=> (rx_push_valid && rx_push_word == {3'b000, $past(tx_byte)}));

    p_ext_drop_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(ctrl_q[7]) && !$past(tx_valid) && rx_push_valid) |-> rx_push_word == 11'h400);

    p_ext_pass_r10: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q[7] && ext_rx_valid) |=> rx_push_valid);
endmodule

bind uart_lpbk_ctrl uart_lpbk_ctrl_chk i_chk (.*);

// File: tb/test_uart_lpbk_ctrl.sv
module test_uart_lpbk_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctrl_we = 1'b0;
    logic [15:0] ctrl_wdata = '0;
    logic [15:0] ctrl_q;
    logic [3:0]  irq_clr = '0;
    logic        m_ri = 1'b0, m_dcd = 1'b0, m_cts = 1'b0, m_dsr = 1'b0;
    logic [8:0]  status_flags;
    logic [3:0]  ms_irq;
    logic        tx_valid = 1'b0;
    logic [7:0]  tx_byte = '0;
    logic        ser_tx_valid;
    logic [7:0]  ser_tx_byte;
    logic        brk_we = 1'b0, brk_val = 1'b0;
    logic        line_break;
    logic        ext_rx_valid = 1'b0;
    logic [7:0]  ext_rx_byte = '0;
    logic        ext_rx_brk = 1'b0;
    logic        rx_push_valid;
    logic [10:0] rx_push_word;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    uart_lpbk_ctrl i_uart_lpbk_ctrl (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_q(ctrl_q),
        .irq_clr(irq_clr), .modem_ri_in(m_ri), .modem_dcd_in(m_dcd),
        .modem_cts_in(m_cts), .modem_dsr_in(m_dsr), .status_flags(status_flags),
        .ms_irq(ms_irq), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .ser_tx_valid(ser_tx_valid), .ser_tx_byte(ser_tx_byte), .brk_we(brk_we),
        .brk_val(brk_val), .line_break(line_break), .ext_rx_valid(ext_rx_valid),
        .ext_rx_byte(ext_rx_byte), .ext_rx_brk(ext_rx_brk),
        .rx_push_valid(rx_push_valid), .rx_push_word(rx_push_word)
    );

    function automatic logic [8:0] exp_flags(input logic [15:0] c);
        return {c[13], 5'b0, c[12], c[10], c[11]};
    endfunction

    function automatic logic [3:0] exp_irq(input logic [15:0] c);
        return {c[10], c[12], c[11], c[13]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // push check: valid flag and word combined
    task automatic chk_push(input string req, input logic v, input logic [10:0] w);
        chk(req, {20'd0, rx_push_valid, (rx_push_valid ? rx_push_word : 11'd0)},
                 {20'd0, v, (v ? w : 11'd0)});
    endtask

    task automatic wr_ctrl(input logic [15:0] v);
        @(negedge clk);
        ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 ctrl", ctrl_q, 32'h0300);
        chk("R1 flags", status_flags, 0);
        chk("R1 irq", ms_irq, 0);
        chk("R1 brk", line_break, 0);
        chk_push("R1 push", 1'b0, 0);
    endtask

    task automatic t_ctrl_rw;
        wr_ctrl(16'h5A3C);
        chk("R2 ctrl", ctrl_q, 32'h5A3C);
        chk("R2 no map when off", status_flags, 0);
        wr_ctrl(16'h0300);
        chk("R2 ctrl back", ctrl_q, 32'h0300);
    endtask

    task automatic t_sync;
        @(negedge clk);
        m_ri = 1'b1; m_cts = 1'b1; m_dsr = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R4 not before 3 edges", status_flags, 0);
        @(negedge clk);
        chk("R4 tracked", status_flags, 32'h103);
        m_ri = 1'b0; m_cts = 1'b0; m_dsr = 1'b0; m_dcd = 1'b1;
        repeat (3) @(negedge clk);
        chk("R4 dcd", status_flags, 32'h004);
        m_dcd = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_external;
        @(negedge clk);
        ext_rx_valid = 1'b1; ext_rx_byte = 8'h5E;
        @(negedge clk);
        ext_rx_brk = 1'b1;
        chk_push("R10 data", 1'b1, 11'h05E);
        @(negedge clk);
        ext_rx_valid = 1'b0; ext_rx_brk = 1'b0;
        chk_push("R10 break", 1'b1, 11'h400);
        brk_we = 1'b1; brk_val = 1'b1;
        @(negedge clk);
        brk_we = 1'b0;
        chk_push("R10 idle", 1'b0, 0);
        @(negedge clk);
        chk_push("R10 no break push off loopback", 1'b0, 0);
        chk("R7 level", line_break, 1);
        brk_we = 1'b1; brk_val = 1'b0;
        @(negedge clk);
        brk_we = 1'b0;
        chk("R7 level low", line_break, 0);
    endtask

    task automatic t_map;
        wr_ctrl(16'h3F80);
        chk("R3 enabling write", status_flags, exp_flags(16'h3F80));
        wr_ctrl(16'h2880);
        chk("R3 pattern A", status_flags, exp_flags(16'h2880));
        wr_ctrl(16'h1480);
        chk("R3 pattern B", status_flags, exp_flags(16'h1480));
    endtask

    task automatic t_irq;
        wr_ctrl(16'h2C80);
        chk("R5 load", ms_irq, exp_irq(16'h2C80));
        @(negedge clk);
        irq_clr = 4'b0001;
        @(negedge clk);
        irq_clr = 4'b0000;
        chk("R5 clear", ms_irq, 32'hA);
        wr_ctrl(16'h1080);
        chk("R5 reload clears", ms_irq, 32'h4);
        @(negedge clk);
        ctrl_we = 1'b1; ctrl_wdata = 16'h2080; irq_clr = 4'hF;
        @(negedge clk);
        ctrl_we = 1'b0; irq_clr = 4'h0;
        chk("R5 write wins", ms_irq, 32'h1);
    endtask

    task automatic t_tx_loop;
        @(negedge clk);
        tx_valid = 1'b1; tx_byte = 8'hA5;
        @(negedge clk);
        tx_valid = 1'b0;
        chk_push("R6 loop", 1'b1, 11'h0A5);
        chk("R6 line", {ser_tx_valid, ser_tx_byte}, 32'h1A5);
        @(negedge clk);
        chk_push("R6 single", 1'b0, 0);
    endtask

    task automatic t_break;
        @(negedge clk);
        brk_we = 1'b1; brk_val = 1'b1;
        @(negedge clk);
        chk_push("R7 rise", 1'b1, 11'h400);
        @(negedge clk);
        brk_we = 1'b0;
        chk_push("R7 no repeat", 1'b0, 0);
        brk_we = 1'b1; brk_val = 1'b0;
        @(negedge clk);
        brk_we = 1'b0;
        chk_push("R7 fall", 1'b0, 0);
        chk("R7 level", line_break, 0);
    endtask

    task automatic t_collide;
        @(negedge clk);
        tx_valid = 1'b1; tx_byte = 8'h11; brk_we = 1'b1; brk_val = 1'b1;
        @(negedge clk);
        brk_we = 1'b0; tx_byte = 8'h22;
        chk_push("R8 tx first", 1'b1, 11'h011);
        @(negedge clk);
        tx_valid = 1'b0;
        chk_push("R8 tx again", 1'b1, 11'h022);
        @(negedge clk);
        chk_push("R8 break later", 1'b1, 11'h400);
        @(negedge clk);
        chk_push("R8 once", 1'b0, 0);
        brk_we = 1'b1; brk_val = 1'b0;
        @(negedge clk);
        brk_we = 1'b0;
    endtask

    task automatic t_ignore;
        wr_ctrl(16'h0080);
        @(negedge clk);
        ext_rx_valid = 1'b1; ext_rx_byte = 8'h77;
        m_ri = 1'b1; m_dcd = 1'b1; m_cts = 1'b1; m_dsr = 1'b1;
        @(negedge clk);
        ext_rx_brk = 1'b1;
        chk_push("R9 data dropped", 1'b0, 0);
        @(negedge clk);
        ext_rx_valid = 1'b0; ext_rx_brk = 1'b0;
        chk_push("R9 break dropped", 1'b0, 0);
        repeat (3) @(negedge clk);
        chk("R9 modem ignored", status_flags, 0);
        wr_ctrl(16'h0300);
        repeat (2) @(negedge clk);
        chk("R4 back to pins", status_flags, 32'h107);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ctrl_rw();
        t_sync();
        t_external();
        t_map();
        t_irq();
        t_tx_loop();
        t_break();
        t_collide();
        t_ignore();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule